// File: doc/BRIEF.md
# Per-Lane Receive Sampling Delay Tuner

This block sits between the serial data input pads and the receive shifter of a quad-capable serial controller. At high serial clock rates the board and pad delay on each data line can differ. The block lets every input lane choose its own capture point and then add a programmable number of module clock cycles, so that all four lanes reach the shifter aligned. A capture point is one of: straight through, the module clock rising edge, the module clock falling edge, or the serial clock rising edge. A swap control reverses the order of the four input lanes before any capture, which suits boards routed the other way round.

On the transmit side each of four output lanes can either pass straight through or be held back to the falling edge of the module clock. This gives half a cycle of launch skew where the pad needs it.

All fields are plain level inputs and are expected to change only between transfers. A field changed while data is moving may glitch the lane for up to the chain depth. No data handshake is involved: every lane is one wire in and one wire out, and there is no back-pressure. The block is a fixed-latency retimer.

Top module: `lane_skew_tuner`

## Requirements
- R1: While `rst_n` is low, every capture register and delay stage is cleared, so a lane whose mode is not 0 drives 0 on `rx_out`.
- R2: Mode code 2'b00 (field `rx_mode[2i+1:2i]` for lane i) routes the lane's selected pin to `rx_out[i]` combinationally, with no delay and no effect from the delay count.
- R3: Mode code 2'b01 captures the selected pin on each module clock rising edge into the first stage of the lane's delay chain.
- R4: Mode code 2'b10 captures the selected pin on each module clock falling edge. The first chain stage loads that capture at the next rising edge.
- R5: Mode code 2'b11 captures the selected pin on each serial clock rising edge. The first chain stage loads the latest such capture at every module clock rising edge.
- R6: The delay count `rx_dly[2i+1:2i]` of value c makes `rx_out[i]` show the first chain stage as it was c rising edges earlier. With mode 2'b01, a pin value present during cycle k appears on the output during cycle k+1+c, which is 1 to 4 cycles of delay.
- R7: With `swap_en` high, lane i takes its input from pin `rx_pin[3-i]` instead of `rx_pin[i]`, in every mode.
- R8: With `tx_late[i]` low, `tx_out[i]` follows `tx_in[i]` combinationally.
- R9: With `tx_late[i]` high, `tx_out[i]` shows the value `tx_in[i]` had at the most recent module clock falling edge, and holds it for one full cycle.
- R10: Each lane's mode and count act on that lane alone. Lanes set to different modes and counts at the same time each behave as R2 to R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| sclk | input | 1 | Serial clock, used by mode 2'b11 capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_en | input | 1 | Reverse the order of the four input lanes |
| rx_pin | input | 4 | Raw data lines from the pads |
| rx_mode | input | 8 | Per-lane capture mode, 2 bits per lane, lane 0 in the low bits |
| rx_dly | input | 8 | Per-lane delay count, 2 bits per lane, lane 0 in the low bits |
| rx_out | output | 4 | Aligned data lines toward the receive shifter |
| tx_in | input | 4 | Transmit data from the shifter |
| tx_late | input | 4 | Per-lane falling-edge launch select |
| tx_out | output | 4 | Data lines toward the pads |

## Verification
The bench changes each input line twice per module clock cycle: once before the falling edge and once after it. Falling-edge and rising-edge capture therefore see different values. A design that mixed up modes 2'b01 and 2'b10 would show the late value where the early one belongs. The serial clock runs at half the module rate, so a mode 2'b11 lane must repeat each serial sample for two cycles. A design that captured on the module clock instead would change every cycle. Every mode is paired with all four counts on all lanes, with the swap off and on. An off-by-one tap, a count that ignored its top bit, or a swap applied to only some modes each shows up as a mismatch against history the bench keeps itself.

// File: rtl/skew_pkg.sv
`timescale 1ns/1ps
package skew_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SMP_PASS = 2'd0,
    SMP_RISE = 2'd1,
    SMP_FALL = 2'd2,
    SMP_SER  = 2'd3
  } smp_mode_e;
endpackage

// File: rtl/skew_lane.sv
`timescale 1ns/1ps
module skew_lane
  import skew_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic [MODE_W-1:0] mode,
  input  logic [CW-1:0]     cnt,
  output logic              dout
);
  logic             fall_q;
  logic             ser_q;
  logic             head;
  logic [DEPTH-1:0] chain;

  // falling-edge capture point
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= raw;
  end

  // serial-clock capture point
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= raw;
  end

  always_comb begin
    case (smp_mode_e'(mode))
      SMP_FALL: head = fall_q;
      SMP_SER:  head = ser_q;
      default:  head = raw;
    endcase
  end

  // delay chain, tap chosen by count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], head};
  end

  assign dout = (smp_mode_e'(mode) == SMP_PASS) ? raw : chain[cnt];

  AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMP_RISE && cnt == '0 && $stable(mode) && $past(rst_n)) |-> dout == $past(raw)); // R3

  AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMP_FALL && cnt == '0 && $stable(mode) && $past(rst_n)) |-> dout == $past(fall_q)); // R4

  AST_SER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMP_SER && cnt == '0 && $stable(mode) && $past(rst_n)) |-> dout == $past(ser_q)); // R5

  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SMP_PASS && cnt != '0 && $stable(mode) && $stable(cnt) && $past(rst_n))
      |-> dout == $past(chain[cnt - 1'b1])); // R6
endmodule

// File: rtl/tx_halfstep.sv
`timescale 1ns/1ps
module tx_halfstep (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic late,
  output logic dout
);
  logic neg_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= din;
  end

  assign dout = late ? neg_q : din;

  AST_TX_LATE: assert property (@(negedge clk) disable iff (!rst_n)
    (late && $past(rst_n)) |-> dout == $past(din)); // R9
endmodule

// File: rtl/lane_skew_tuner.sv
`timescale 1ns/1ps
module lane_skew_tuner
  import skew_pkg::*;
#(
  parameter  int LANES = 4,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    sclk,
  input  logic                    rst_n,
  input  logic                    swap_en,
  input  logic [LANES-1:0]        rx_pin,
  input  logic [LANES*MODE_W-1:0] rx_mode,
  input  logic [LANES*CW-1:0]     rx_dly,
  output logic [LANES-1:0]        rx_out,
  input  logic [LANES-1:0]        tx_in,
  input  logic [LANES-1:0]        tx_late,
  output logic [LANES-1:0]        tx_out
);
  logic [LANES-1:0] lane_raw;

  for (genvar i = 0; i < LANES; i++) begin : g_rx
    // R7: lane order reversal ahead of every capture point
    assign lane_raw[i] = swap_en ? rx_pin[LANES-1-i] : rx_pin[i];

    skew_lane #(.DEPTH(DEPTH)) u_lane (
      .clk  (clk),
      .sclk (sclk),
      .rst_n(rst_n),
      .raw  (lane_raw[i]),
      .mode (rx_mode[i*MODE_W +: MODE_W]),
      .cnt  (rx_dly[i*CW +: CW]),
      .dout (rx_out[i])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_tx
    tx_halfstep u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (tx_in[i]),
      .late (tx_late[i]),
      .dout (tx_out[i])
    );
  end
endmodule

// File: tb/sim_lane_skew_tuner.sv
`timescale 1ns/1ps
module sim_lane_skew_tuner;
  localparam int CLK_PERIOD = 10;
  localparam int T = CLK_PERIOD / 10;
  localparam int HIST = 1024;

  logic       clk = 1'b0;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swap_en = 1'b0;
  logic [3:0] rx_pin = '0;
  logic [7:0] rx_mode = '0;
  logic [7:0] rx_dly = '0;
  logic [3:0] rx_out;
  logic [3:0] tx_in = '0;
  logic [3:0] tx_late = '0;
  logic [3:0] tx_out;

  int vectors = 0;
  int misses = 0;
  int cyc = 0;
  bit done = 0;

  logic [3:0] ah [HIST];
  logic [3:0] bh [HIST];
  logic [3:0] tah [HIST];
  logic [3:0] tbh [HIST];
  int md [4];
  int ct [4];

  lane_skew_tuner u0 (
    .clk(clk), .sclk(sclk), .rst_n(rst_n), .swap_en(swap_en),
    .rx_pin(rx_pin), .rx_mode(rx_mode), .rx_dly(rx_dly), .rx_out(rx_out),
    .tx_in(tx_in), .tx_late(tx_late), .tx_out(tx_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int lane, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s lane %0d cycle %0d: actual %b expected %b", tag, lane, cyc, act, exp);
    end
  endtask

  task automatic push_cfg();
    for (int i = 0; i < 4; i++) begin
      rx_mode[2*i +: 2] = 2'(md[i]);
      rx_dly[2*i +: 2]  = 2'(ct[i]);
    end
  endtask

  function automatic logic rx_expect(input int lane);
    int p = swap_en ? 3 - lane : lane;
    int k = cyc - 1 - ct[lane];
    case (md[lane])
      0:       return bh[cyc][p];
      1:       return bh[k][p];
      2:       return ah[k][p];
      default: return ah[k - (k % 2)][p];
    endcase
  endfunction

  // one module clock cycle: early value, serial edge, late value, sample
  task automatic step(input bit do_rx, input bit do_tx, input bit in_reset);
    @(posedge clk);
    cyc++;
    #(T);
    ah[cyc] = 4'($urandom()); tah[cyc] = 4'($urandom());
    rx_pin = ah[cyc]; tx_in = tah[cyc];
    #(2*T);
    sclk = (cyc % 2 == 0);
    #(3*T);
    bh[cyc] = 4'($urandom()); tbh[cyc] = 4'($urandom());
    rx_pin = bh[cyc]; tx_in = tbh[cyc];
    #(2*T);
    if (in_reset) begin
      chk("R2 pass in reset", 0, rx_out[0], bh[cyc][0]);
      for (int i = 1; i < 4; i++) chk("R1 reset clear", i, rx_out[i], 1'b0);
    end
    if (do_rx) begin
      for (int i = 0; i < 4; i++) begin
        string tag;
        case (md[i])
          0: tag = "R2 pass";
          1: tag = "R3 rise R6 count R10";
          2: tag = "R4 fall R6 count R10";
          default: tag = "R5 serial R6 count R10";
        endcase
        if (swap_en) tag = {tag, " R7 swap"};
        chk(tag, i, rx_out[i], rx_expect(i));
      end
    end
    if (do_tx) begin
      for (int i = 0; i < 4; i++) begin
        if (tx_late[i]) chk("R9 tx late", i, tx_out[i], tah[cyc][i]);
        else            chk("R8 tx direct", i, tx_out[i], tbh[cyc][i]);
      end
    end
  endtask

  initial begin
    md[0] = 0; ct[0] = 3;
    for (int i = 1; i < 4; i++) begin md[i] = 1; ct[i] = i; end
    push_cfg();
    for (int n = 0; n < 4; n++) step(0, 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) step(0, 0, 0);

    for (int sw = 0; sw < 2; sw++) begin
      swap_en = sw[0];
      for (int combo = 0; combo < 16; combo++) begin
        for (int i = 0; i < 4; i++) begin
          int v = (combo + 5*i) % 16;
          md[i] = v / 4;
          ct[i] = v % 4;
        end
        push_cfg();
        for (int n = 0; n < 4; n++) step(0, 0, 0);
        for (int n = 0; n < 8; n++) step(1, 0, 0);
      end
    end

    for (int pat = 0; pat < 16; pat++) begin
      tx_late = 4'(pat);
      step(0, 0, 0);
      for (int n = 0; n < 3; n++) step(0, 1, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule